// File: doc/BRIEF.md
# GPIO Controller with Edge Interrupts

A thirteen-pin general-purpose I/O block behind a byte-wide register port. Every pin owns two registers. The output-control register chooses the pin direction, the driver style (push-pull or open-drain), whether a pull resistor is connected and which one, and the level to drive. The input-control register returns the synchronised pin level and selects which transitions count as interrupt events.

Interrupt events latch into status bits. These bits are packed with their mask bits into two groups: pins 0–6 form a seven-bit group and pins 7–12 form a six-bit group. Software clears a status bit by writing 1 to it. A single `irq_o` line is raised while any status bit has its mask bit at 0. On the pad side, the block only produces the enable, value and pull-select signals that a pad cell consumes.

The pins fall into three banks: bank 0 holds pins 0–6, bank 1 holds pins 7–10 and bank 2 holds pins 11–12. The interrupt grouping follows this split: bank 0 forms group 0, and banks 1 and 2 together form group 1.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every pin is an input with `pad_oe_o` low, every edge selection is off, both mask registers read all ones in their implemented bits, both status registers read 0 and `irq_o` is low.
- R2: The address map is as follows:
  - Output control of pin n sits at address n (0–12).
  - Input control of pin n sits at address 13+n.
  - The group 0 status register is at 26 and the group 1 status register is at 27.
  - The group 0 mask register is at 28 and the group 1 mask register is at 29.
  - Unimplemented bits read 0: output-control bits 7:6, input-control bits 7:3, bit 7 in the group 0 registers and bits 7:6 in the group 1 registers.
- R3: Output-control bit 5 is the direction (1 = output) and bit 4 is the driver style (1 = push-pull, 0 = open-drain). Bit 0 is the level and appears on `pad_out_o`. `pad_oe_o` equals dir AND (push-pull OR NOT level), so an open-drain pin only drives a low level.
- R4: Output-control bit 3 appears on `pull_en_o[n]`. Bits 2:1 appear on `pull_sel_o[2n+1:2n]`, encoded as 00 strong down, 01 strong up, 10 weak down and 11 weak up.
- R5: Input-control bit 0 returns the pad level through a two-flop synchroniser. A pad change made before clock edge k is readable after edge k+1 and not after edge k.
- R6: Input-control bits 2:1 select the events: 00 none, 01 falling, 10 rising, 11 both. A qualifying pad change made before edge k sets the status bit at edge k+2. A non-qualifying change leaves the status bit at 0.
- R7: Pin n (n<7) maps to bit n of the group 0 status and mask registers. Pin n (n≥7) maps to bit n-7 of the group 1 registers.
- R8: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R9: When an event and a clear of the same status bit land on the same clock edge, the bit stays set.
- R10: A status bit latches whatever its mask bit holds. `irq_o` is the OR of every status bit whose mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 5 | Register address |
| wr_en_i | input | 1 | Write strobe, takes effect at the clock edge |
| wdata_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for `addr_i`, combinational |
| pad_i | input | 13 | Pad input levels, asynchronous |
| pad_oe_o | output | 13 | Pad output enable per pin |
| pad_out_o | output | 13 | Pad output value per pin |
| pull_en_o | output | 13 | Pull resistor enable per pin |
| pull_sel_o | output | 26 | Pull select, two bits per pin |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default parameters: thirteen pins and a 7/6 group split. These keep every pin and both group boundaries small enough to sweep completely. For every pin, each of the four edge selections is driven through a rising and then a falling transition. For every pin, all 64 output-control codes are swept. This covers each pin-to-group bit mapping, including the 6→7 boundary. The same-edge collision between an event and a clear is placed on an exact cycle, using the two-flop synchroniser latency.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  // field order matches output-control bits 5..0
  typedef struct packed {
    logic       dir_out;
    logic       push_pull;
    logic       pull_en;
    logic [1:0] pull_sel;
    logic       level;
  } octl_t;

  localparam int unsigned OCTL_W = $bits(octl_t);

  function automatic logic edge_hit(edge_sel_e sel, logic rise, logic fall);
    return (sel[1] & rise) | (sel[0] & fall);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det
  import gpio_edge_pkg::*;
#(
  parameter int unsigned WIDTH = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  input  edge_sel_e        sel_i [WIDTH],
  output logic [WIDTH-1:0] edge_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    logic rise, fall;
    assign rise      = lvl_i[p] & ~prev_q[p];
    assign fall      = ~lvl_i[p] & prev_q[p];
    assign edge_o[p] = edge_hit(sel_i[p], rise, fall);
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int unsigned NUM_PINS  = 13,
  parameter int unsigned GRP0_PINS = 7,
  localparam int unsigned GRP1_PINS = NUM_PINS - GRP0_PINS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PINS-1:0]  edge_i,
  input  logic [1:0]           sts_wr_i,   // write strobe per group
  input  logic [1:0]           msk_wr_i,
  input  logic [7:0]           wdata_i,
  output logic [NUM_PINS-1:0]  sts_o,
  output logic [NUM_PINS-1:0]  msk_o,
  output logic [NUM_PINS-1:0]  clr_o,
  output logic [GRP0_PINS-1:0] sts_g0_o,
  output logic [GRP1_PINS-1:0] sts_g1_o,
  output logic [GRP0_PINS-1:0] msk_g0_o,
  output logic [GRP1_PINS-1:0] msk_g1_o,
  output logic                 irq_o
);
  logic [NUM_PINS-1:0] sts_q, msk_q, msk_we, msk_d;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int unsigned GRP = (p < GRP0_PINS) ? 0 : 1;
    localparam int unsigned BIT = (p < GRP0_PINS) ? p : p - GRP0_PINS;

    assign clr_o[p]  = sts_wr_i[GRP] & wdata_i[BIT];
    assign msk_we[p] = msk_wr_i[GRP];
    assign msk_d[p]  = wdata_i[BIT];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        sts_q[p] <= 1'b0;
      else if (edge_i[p]) sts_q[p] <= 1'b1;  // event wins over clear
      else if (clr_o[p])  sts_q[p] <= 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        msk_q[p] <= 1'b1;
      else if (msk_we[p]) msk_q[p] <= msk_d[p];
    end

    if (p < GRP0_PINS) begin : g_g0
      assign sts_g0_o[BIT] = sts_q[p];
      assign msk_g0_o[BIT] = msk_q[p];
    end else begin : g_g1
      assign sts_g1_o[BIT] = sts_q[p];
      assign msk_g1_o[BIT] = msk_q[p];
    end
  end

  assign sts_o = sts_q;
  assign msk_o = msk_q;
  assign irq_o = |(sts_q & ~msk_q);
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 13,
  parameter int unsigned GRP0_PINS = 7,
  parameter int unsigned ADDR_W    = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  wr_en_i,
  input  logic [7:0]            wdata_i,
  output logic [7:0]            rd_data_o,
  input  logic [NUM_PINS-1:0]   pad_i,
  output logic [NUM_PINS-1:0]   pad_oe_o,
  output logic [NUM_PINS-1:0]   pad_out_o,
  output logic [NUM_PINS-1:0]   pull_en_o,
  output logic [2*NUM_PINS-1:0] pull_sel_o,
  output logic                  irq_o
);
  localparam int unsigned GRP1_PINS = NUM_PINS - GRP0_PINS;
  localparam int unsigned OCTL_BASE = 0;
  localparam int unsigned ICTL_BASE = OCTL_BASE + NUM_PINS;
  localparam int unsigned STS_BASE  = ICTL_BASE + NUM_PINS;
  localparam int unsigned MSK_BASE  = STS_BASE + 2;

  octl_t               octl_q [NUM_PINS];
  edge_sel_e           ectl_q [NUM_PINS];
  logic [NUM_PINS-1:0] lvl, edge_pulse, sts_vec, msk_vec, sts_clr, dir_vec;
  logic [1:0]          sts_wr, msk_wr;
  logic [GRP0_PINS-1:0] sts_g0, msk_g0;
  logic [GRP1_PINS-1:0] sts_g1, msk_g1;

  // register file
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_reg
    logic octl_we, ectl_we;
    assign octl_we = wr_en_i && (addr_i == ADDR_W'(OCTL_BASE + p));
    assign ectl_we = wr_en_i && (addr_i == ADDR_W'(ICTL_BASE + p));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        octl_q[p] <= '0;
        ectl_q[p] <= EDGE_OFF;
      end else begin
        if (octl_we) octl_q[p] <= octl_t'(wdata_i[OCTL_W-1:0]);
        if (ectl_we) ectl_q[p] <= edge_sel_e'(wdata_i[2:1]);
      end
    end

    assign dir_vec[p]          = octl_q[p].dir_out;
    assign pad_out_o[p]        = octl_q[p].level;
    assign pad_oe_o[p]         = octl_q[p].dir_out &
                                 (octl_q[p].push_pull | ~octl_q[p].level);
    assign pull_en_o[p]        = octl_q[p].pull_en;
    assign pull_sel_o[2*p +: 2] = octl_q[p].pull_sel;
  end

  for (genvar g = 0; g < 2; g++) begin : g_grp
    assign sts_wr[g] = wr_en_i && (addr_i == ADDR_W'(STS_BASE + g));
    assign msk_wr[g] = wr_en_i && (addr_i == ADDR_W'(MSK_BASE + g));
  end

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (lvl)
  );

  gpio_edge_det #(.WIDTH(NUM_PINS)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .sel_i (ectl_q),
    .edge_o(edge_pulse)
  );

  gpio_irq_bank #(.NUM_PINS(NUM_PINS), .GRP0_PINS(GRP0_PINS)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .edge_i  (edge_pulse),
    .sts_wr_i(sts_wr),
    .msk_wr_i(msk_wr),
    .wdata_i (wdata_i),
    .sts_o   (sts_vec),
    .msk_o   (msk_vec),
    .clr_o   (sts_clr),
    .sts_g0_o(sts_g0),
    .sts_g1_o(sts_g1),
    .msk_g0_o(msk_g0),
    .msk_g1_o(msk_g1),
    .irq_o   (irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (addr_i == ADDR_W'(OCTL_BASE + p)) rd_data_o = 8'(octl_q[p]);
      if (addr_i == ADDR_W'(ICTL_BASE + p)) rd_data_o = 8'({ectl_q[p], lvl[p]});
    end
    if (addr_i == ADDR_W'(STS_BASE))     rd_data_o = 8'(sts_g0);
    if (addr_i == ADDR_W'(STS_BASE + 1)) rd_data_o = 8'(sts_g1);
    if (addr_i == ADDR_W'(MSK_BASE))     rd_data_o = 8'(msk_g0);
    if (addr_i == ADDR_W'(MSK_BASE + 1)) rd_data_o = 8'(msk_g1);
  end
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
  parameter int unsigned NUM_PINS = 13
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_PINS-1:0] edge_vec,
  input logic [NUM_PINS-1:0] clr_vec,
  input logic [NUM_PINS-1:0] sts_vec,
  input logic [NUM_PINS-1:0] msk_vec,
  input logic [NUM_PINS-1:0] dir_vec,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic                irq
);
  p_edge_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|edge_vec) |=> ((sts_vec & $past(edge_vec)) == $past(edge_vec)));

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_vec & ~edge_vec)) |=> ((sts_vec & $past(clr_vec & ~edge_vec)) == '0));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((edge_vec | clr_vec) == '0) |=> $stable(sts_vec));

  p_race_keeps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(edge_vec & clr_vec)) |=>
      ((sts_vec & $past(edge_vec & clr_vec)) == $past(edge_vec & clr_vec)));

  p_all_masked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&msk_vec) |-> !irq);

  p_input_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_vec == '0) |-> (pad_oe == '0));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .edge_vec(edge_pulse),
  .clr_vec (sts_clr),
  .sts_vec (sts_vec),
  .msk_vec (msk_vec),
  .dir_vec (dir_vec),
  .pad_oe  (pad_oe_o),
  .irq     (irq_o)
);

// File: tb/gpio_edge_ctrl_test.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_test;
  localparam int N = 13;
  localparam int G0 = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    addr = '0;
  logic          wr_en = 1'b0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rd_data;
  logic [N-1:0]  pad = '0;
  logic [N-1:0]  pad_oe, pad_out, pull_en;
  logic [2*N-1:0] pull_sel;
  logic          irq;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_edge_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rd_data_o(rd_data), .pad_i(pad), .pad_oe_o(pad_oe),
    .pad_out_o(pad_out), .pull_en_o(pull_en), .pull_sel_o(pull_sel), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic pad_set(input int p, input logic v);
    @(negedge clk);
    pad[p] = v;
    repeat (3) @(posedge clk);
  endtask

  function automatic int grp_of(input int p); return (p < G0) ? 0 : 1; endfunction
  function automatic int bit_of(input int p); return (p < G0) ? p : p - G0; endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk("R1 pad_oe", 32'(pad_oe), 0);
    chk("R1 irq", 32'(irq), 0);
    rd(5'd28, v); chk("R1 mask g0", 32'(v), 32'h7f);
    rd(5'd29, v); chk("R1 mask g1", 32'(v), 32'h3f);
    rd(5'd26, v); chk("R1 sts g0", 32'(v), 0);
    rd(5'd27, v); chk("R1 sts g1", 32'(v), 0);
    for (int p = 0; p < N; p++) begin
      rd(5'(13 + p), v); chk("R1 ictl edge off", 32'(v), 0);
    end

    // R3 R4 R2: output control sweep
    for (int p = 0; p < N; p++) begin
      for (int c = 0; c < 64; c++) begin
        logic [5:0] cv;
        cv = 6'(c);
        wr(5'(p), {2'b11, cv});
        rd(5'(p), v);
        chk("R2 octl readback", 32'(v), 32'(cv));
        chk("R3 pad_out", 32'(pad_out[p]), 32'(cv[0]));
        chk("R3 pad_oe", 32'(pad_oe[p]), 32'(cv[5] & (cv[4] | ~cv[0])));
        chk("R4 pull_en", 32'(pull_en[p]), 32'(cv[3]));
        chk("R4 pull_sel", 32'(pull_sel[2*p +: 2]), 32'(cv[2:1]));
      end
      wr(5'(p), 8'h00);
    end

    // R2 ictl unimplemented bits
    wr(5'd13, 8'hff);
    rd(5'd13, v); chk("R2 ictl bits", 32'(v), 32'h06);
    wr(5'd13, 8'h00);

    // R5 synchroniser latency
    @(negedge clk); pad[4] = 1'b1;
    @(posedge clk);
    rd(5'd17, v); chk("R5 level after one edge", 32'(v[0]), 0);
    @(posedge clk);
    rd(5'd17, v); chk("R5 level after two edges", 32'(v[0]), 1);
    pad_set(4, 1'b0);

    // R6 R7 R10 edge sweep, masks open
    wr(5'd28, 8'h00);
    wr(5'd29, 8'h00);
    for (int p = 0; p < N; p++) begin
      for (int m = 0; m < 4; m++) begin
        logic [7:0] exp_v;
        wr(5'(13 + p), 8'(m << 1));
        pad_set(p, 1'b1);
        exp_v = (m[1]) ? 8'(1 << bit_of(p)) : 8'h00;
        rd(5'(26 + grp_of(p)), v); chk("R6 R7 rise status", 32'(v), 32'(exp_v));
        rd(5'(26 + 1 - grp_of(p)), v); chk("R7 other group", 32'(v), 0);
        chk("R10 irq rise", 32'(irq), 32'(m[1]));
        rd(5'(13 + p), v); chk("R5 level high", 32'(v), 32'((m << 1) | 1));
        wr(5'(26 + grp_of(p)), 8'hff);
        pad_set(p, 1'b0);
        exp_v = (m[0]) ? 8'(1 << bit_of(p)) : 8'h00;
        rd(5'(26 + grp_of(p)), v); chk("R6 R7 fall status", 32'(v), 32'(exp_v));
        chk("R10 irq fall", 32'(irq), 32'(m[0]));
        wr(5'(26 + grp_of(p)), 8'hff);
        rd(5'(26 + grp_of(p)), v); chk("R8 cleared", 32'(v), 0);
      end
      wr(5'(13 + p), 8'h00);
    end

    // R10 masked pin still latches; unmask raises irq
    wr(5'd29, 8'h3f);
    wr(5'd22, 8'h04);           // pin 9 rising
    pad_set(9, 1'b1);
    rd(5'd27, v); chk("R10 latched while masked", 32'(v), 32'h04);
    chk("R10 irq masked", 32'(irq), 0);
    wr(5'd29, 8'h3b);
    chk("R10 irq unmasked", 32'(irq), 1);
    rd(5'd29, v); chk("R2 mask readback", 32'(v), 32'h3b);

    // R8 write zero keeps, write one clears
    wr(5'd27, 8'h3b);
    rd(5'd27, v); chk("R8 write 0 keeps", 32'(v), 32'h04);
    wr(5'd27, 8'h04);
    rd(5'd27, v); chk("R8 write 1 clears", 32'(v), 0);
    chk("R10 irq after clear", 32'(irq), 0);
    pad_set(9, 1'b0);
    wr(5'd22, 8'h00);

    // R9 event and clear on same edge (pin 0, both edges)
    wr(5'd13, 8'h06);
    pad_set(0, 1'b1);
    rd(5'd26, v); chk("R9 setup", 32'(v), 32'h01);
    @(negedge clk); pad[0] = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk); addr = 5'd26; wdata = 8'h01; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
    rd(5'd26, v); chk("R9 event wins over clear", 32'(v), 32'h01);
    wr(5'd26, 8'h01);
    rd(5'd26, v); chk("R9 later clear", 32'(v), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule